// File: doc/BRIEF.md
# Synchronous Serial Position Transmitter

This block sits on the sensor side of a synchronous serial link. A controller
sends bursts on a clock line. The block answers each burst with one frame on a
single data line, and the controller's clock paces the frame. The frame holds a
status bit that is active high and a run of zero padding bits, followed by a
parallel position word that is sent most significant bit first. On the first
falling edge of a burst the block captures the position word and the status
bit, so the whole frame comes from one snapshot.

Controllers do not always send the expected number of clock edges, so a
monoflop timer closes every frame. If a burst stops early, the current bit is
held, and then the timer expires and ends the frame. If a burst carries extra
edges, the line is pulled low, and every extra falling edge restarts the timer.
The block also measures the spacing of clock edges in system-clock cycles and
flags a clock that is too fast. It raises the status bit for an external error
event or for a too-fast clock. After the cause goes away, one more frame still
carries the status bit.

Top module: `ssi_position_tx`

## Requirements
- R1: After reset, ssiData is 1 and clkTooFast is 0.
- R2: While no frame is active, ssiData is 1. The first falling edge of ssiClk starts a frame. ssiData stays 1 until the first rising edge of that frame.
- R3: A frame is FRAME_W = 1 + NULL_BITS + POS_W bits long. Each rising edge of ssiClk puts the next bit on ssiData, three system-clock cycles after the edge. The bits are, in order: the status bit, then NULL_BITS zeros, then posWord from its most significant bit down. Each bit holds until the next rising edge.
- R4: posWord is sampled on the falling edge that starts a frame. Any later change has no effect on that frame.
- R5: If no clock edge arrives for TM_CYCLES system cycles while a frame is active, ssiData goes to 0. It returns to 1 after a further TM_CYCLES cycles without a falling edge. This applies both to a completed frame and to one that was cut short.
- R6: During a frame, an edge that arrives before the timeout restarts the timer. The frame then continues with its next bit on the next rising edge.
- R7: A rising edge after all FRAME_W bits have been sent drives ssiData to 0. In that low phase, each falling edge restarts the timer. ssiData returns to 1 only TM_CYCLES cycles after the last falling edge.
- R8: During a frame or its low phase, two ssiClk edges closer than MIN_HALF system cycles set clkTooFast. It stays 1 until ssiData returns to 1 at the end of that frame. Edges exactly MIN_HALF cycles apart do not set it.
- R9: The status bit of a frame is 1 if errEvent or clkTooFast was 1 at any cycle since the previous frame started. Otherwise it is 0. So once the cause clears, exactly one further frame reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ssiClk | input | 1 | Serial clock from the controller, idles high |
| posWord | input | POS_W | Parallel position value |
| errEvent | input | 1 | Error condition, active high |
| ssiData | output | 1 | Serial data line |
| clkTooFast | output | 1 | Serial clock edge spacing below MIN_HALF |

## Verification
The assertions assume that ssiClk idles high between bursts. They also assume
that each level of ssiClk lasts at least one system-clock cycle, so every
toggle reaches the synchronizer. The bench changes ssiClk and posWord only on
the falling edge of the system clock, and it holds every half period for a
whole number of cycles. Half periods of 3, 4 and 6 cycles exercise the
too-fast threshold on both sides. Before each new burst, the bench waits
longer than twice TM_CYCLES, so every frame starts from the idle state.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } txState_t;

  typedef struct packed {
    logic load;      // capture a new frame
    logic shiftOut;  // put next frame bit on the line
    logic lineLow;   // force the line low
    logic lineHigh;  // release the line high
    logic tmrClr;    // restart the monoflop timer
  } txStrobe_t;

endpackage

// File: rtl/ssi_tx_datapath.sv
module ssi_tx_datapath
  import ssi_tx_pkg::*;
#(
  parameter int POS_W     = 24,
  parameter int NULL_BITS = 1,
  parameter int TM_CYCLES = 4000,
  parameter int MIN_HALF  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ssiClk,
  input  logic [POS_W-1:0] posWord,
  input  logic             errBit,
  input  txStrobe_t        strobe,
  output logic             rise,
  output logic             fall,
  output logic             lastBit,
  output logic             tmrDone,
  output logic             gapShort,
  output logic             ssiData
);

  localparam int SYNC_STAGES = 2;
  localparam int FRAME_W     = 1 + NULL_BITS + POS_W;
  localparam int CNT_W       = $clog2(FRAME_W + 1);
  localparam int TMR_W       = $clog2(TM_CYCLES);
  localparam int GAP_W       = $clog2(MIN_HALF + 1);

  // Synchronizer and edge detector; reset to the idle (high) level
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], ssiClk};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rise = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign fall = ~syncQ[SYNC_STAGES-1] & prevQ;

  // Frame shift register and bit counter
  logic [FRAME_W-1:0] shReg;
  logic [CNT_W-1:0]   bitCnt;
  logic [FRAME_W-1:0] frameWord;

  assign frameWord = {errBit, {NULL_BITS{1'b0}}, posWord};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (strobe.load) begin
      shReg  <= frameWord;
      bitCnt <= '0;
    end else if (strobe.shiftOut) begin
      shReg  <= {shReg[FRAME_W-2:0], 1'b0};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign lastBit = (bitCnt == CNT_W'(FRAME_W));

  // Monoflop timer
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= '0;
    else if (strobe.tmrClr) tmr <= '0;
    else                    tmr <= tmr + 1'b1;
  end

  assign tmrDone = (tmr == TMR_W'(TM_CYCLES - 1));

  // Edge spacing counter (saturates at MIN_HALF)
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          gap <= GAP_W'(MIN_HALF);
    else if (rise || fall)              gap <= '0;
    else if (gap < GAP_W'(MIN_HALF))    gap <= gap + 1'b1;
  end

  assign gapShort = (gap < GAP_W'(MIN_HALF - 1));

  // Line driver register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ssiData <= 1'b1;
    else if (strobe.lineHigh)  ssiData <= 1'b1;
    else if (strobe.lineLow)   ssiData <= 1'b0;
    else if (strobe.shiftOut)  ssiData <= shReg[FRAME_W-1];
  end

  // R3: the line changes only on a strobe from control
  a_r3_line_only_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.lineHigh || strobe.lineLow || strobe.shiftOut) |=> $stable(ssiData));

endmodule

// File: rtl/ssi_tx_ctrl.sv
module ssi_tx_ctrl
  import ssi_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rise,
  input  logic      fall,
  input  logic      lastBit,
  input  logic      tmrDone,
  input  logic      gapShort,
  input  logic      errEvent,
  output txStrobe_t strobe,
  output txState_t  state,
  output logic      errBit,
  output logic      tooFast
);

  txState_t nxtState;
  logic     setFast;
  logic     errFlag;

  always_comb begin
    strobe   = '0;
    nxtState = state;
    unique case (state)
      ST_IDLE: begin
        strobe.tmrClr = 1'b1;
        if (fall) begin
          strobe.load = 1'b1;
          nxtState    = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (rise) begin
          strobe.tmrClr = 1'b1;
          if (lastBit) begin
            strobe.lineLow = 1'b1;
            nxtState       = ST_TAIL;
          end else begin
            strobe.shiftOut = 1'b1;
          end
        end else if (fall) begin
          strobe.tmrClr = 1'b1;
        end else if (tmrDone) begin
          strobe.tmrClr  = 1'b1;
          strobe.lineLow = 1'b1;
          nxtState       = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (fall) begin
          strobe.tmrClr = 1'b1;
        end else if (tmrDone) begin
          strobe.tmrClr   = 1'b1;
          strobe.lineHigh = 1'b1;
          nxtState        = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign setFast = (rise || fall) && gapShort && (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tooFast <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= nxtState;
      if (setFast)                            tooFast <= 1'b1;
      else if (strobe.lineHigh || strobe.load) tooFast <= 1'b0;
      errFlag <= errEvent | tooFast | (errFlag & ~strobe.load);
    end
  end

  assign errBit = errFlag;

  // R8: the too-fast flag never rises while idle
  a_r8_fast_needs_burst: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tooFast) |-> $past(state) != ST_IDLE);

  // R9: an active error cause keeps the pending status set
  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errEvent |=> errFlag);

endmodule

// File: rtl/ssi_position_tx.sv
module ssi_position_tx
  import ssi_tx_pkg::*;
#(
  parameter int POS_W     = 24,
  parameter int NULL_BITS = 1,
  parameter int TM_CYCLES = 4000,
  parameter int MIN_HALF  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ssiClk,
  input  logic [POS_W-1:0] posWord,
  input  logic             errEvent,
  output logic             ssiData,
  output logic             clkTooFast
);

  txStrobe_t strobe;
  txState_t  state;
  logic      rise, fall, lastBit, tmrDone, gapShort, errBit;

  ssi_tx_datapath #(
    .POS_W     (POS_W),
    .NULL_BITS (NULL_BITS),
    .TM_CYCLES (TM_CYCLES),
    .MIN_HALF  (MIN_HALF)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ssiClk   (ssiClk),
    .posWord  (posWord),
    .errBit   (errBit),
    .strobe   (strobe),
    .rise     (rise),
    .fall     (fall),
    .lastBit  (lastBit),
    .tmrDone  (tmrDone),
    .gapShort (gapShort),
    .ssiData  (ssiData)
  );

  ssi_tx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rise     (rise),
    .fall     (fall),
    .lastBit  (lastBit),
    .tmrDone  (tmrDone),
    .gapShort (gapShort),
    .errEvent (errEvent),
    .strobe   (strobe),
    .state    (state),
    .errBit   (errBit),
    .tooFast  (clkTooFast)
  );

  // R2: idle line is high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> ssiData);

  // R5: low phase drives the line low
  a_r5_tail_low: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_TAIL |-> !ssiData);

  // R3: a bit holds between rising edges unless the timer expires
  a_r3_hold_bit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && !rise && !tmrDone) |=> $stable(ssiData));

  // R7: a falling edge in the low phase keeps the frame from ending
  a_r7_fall_retriggers: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TAIL && fall) |=> state == ST_TAIL);

endmodule

// File: tb/ssi_position_tx_tb.sv
`timescale 1ns/1ps
module ssi_position_tx_tb;

  localparam int POS_W   = 16;
  localparam int NULLS   = 3;
  localparam int TM      = 48;
  localparam int MINH    = 4;
  localparam int FRAME_W = 1 + NULLS + POS_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ssiClk = 1'b1;
  logic [POS_W-1:0] posWord = 16'hA5C3;
  logic             errEvent = 1'b0;
  logic             ssiData;
  logic             clkTooFast;

  always #2.5 clk = ~clk;

  ssi_position_tx #(
    .POS_W     (POS_W),
    .NULL_BITS (NULLS),
    .TM_CYCLES (TM),
    .MIN_HALF  (MINH)
  ) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .ssiClk     (ssiClk),
    .posWord    (posWord),
    .errEvent   (errEvent),
    .ssiData    (ssiData),
    .clkTooFast (clkTooFast)
  );

  int    nChecks = 0;
  int    nErrors = 0;
  string curReq  = "R1";
  bit    cmpOn   = 1'b0;
  bit    finished = 1'b0;
  int    cycles  = 0;
  logic  firstBit;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
  endtask

  // Behavioural reference model, updated on every rising clock edge
  bit mS1 = 1, mS2 = 1, mPrev = 1;
  int phase = 0;      // 0 idle, 1 sending, 2 low phase
  int quiet = 0;      // cycles without a restarting edge
  int gapM  = MINH;   // cycles since last edge
  bit mLine = 1, mFast = 0, mErr = 0;
  bit bitQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mPrev = 1; phase = 0; quiet = 0; gapM = MINH;
      mLine = 1; mFast = 0; mErr = 0; bitQ.delete();
    end else begin
      bit r, f, ld, endF, setF, errNew;
      r = mS2 & !mPrev;
      f = !mS2 & mPrev;
      ld = (phase == 0) && f;
      endF = 0;
      setF = (r || f) && (phase != 0) && (gapM < MINH - 1);
      errNew = errEvent | mFast | (mErr & !ld);
      case (phase)
        0: begin
          quiet = 0;
          if (f) begin
            bitQ.delete();
            bitQ.push_back(mErr);
            for (int i = 0; i < NULLS; i++) bitQ.push_back(1'b0);
            for (int i = POS_W - 1; i >= 0; i--) bitQ.push_back(posWord[i]);
            phase = 1;
          end
        end
        1: begin
          if (r) begin
            quiet = 0;
            if (bitQ.size() > 0) mLine = bitQ.pop_front();
            else begin mLine = 0; phase = 2; end
          end else if (f) quiet = 0;
          else if (quiet == TM - 1) begin quiet = 0; mLine = 0; phase = 2; end
          else quiet++;
        end
        default: begin
          if (f) quiet = 0;
          else if (quiet == TM - 1) begin quiet = 0; mLine = 1; phase = 0; endF = 1; end
          else quiet++;
        end
      endcase
      if (r || f) gapM = 0;
      else if (gapM < MINH) gapM++;
      if (setF) mFast = 1;
      else if (endF || ld) mFast = 0;
      mErr = errNew;
      mPrev = mS2; mS2 = mS1; mS1 = ssiClk;
    end
  end

  // Per-cycle comparison and watchdog
  always @(negedge clk) begin
    cycles++;
    if (cmpOn && rstN) begin
      check(ssiData === mLine, curReq, "ssiData vs model", int'(ssiData), int'(mLine));
      check(clkTooFast === mFast, curReq, "clkTooFast vs model", int'(clkTooFast), int'(mFast));
    end
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", "timeout", cycles, 150000);
      summary();
      $finish;
    end
  end

  task automatic burst(int nRise, int half);
    for (int i = 0; i < nRise; i++) begin
      ssiClk = 1'b0;
      repeat (half) @(negedge clk);
      ssiClk = 1'b1;
      repeat (half) @(negedge clk);
      if (i == 0) firstBit = ssiData;
    end
  endtask

  task automatic idleWait();
    repeat (2 * TM + 20) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;
    // R1: reset state
    check(ssiData === 1'b1, "R1", "ssiData after reset", int'(ssiData), 1);
    check(clkTooFast === 1'b0, "R1", "clkTooFast after reset", int'(clkTooFast), 0);

    // R2, R3: normal frame, status bit 0 first
    curReq = "R3";
    burst(FRAME_W, 6);
    check(firstBit === 1'b0, "R3", "status bit", int'(firstBit), 0);
    curReq = "R2";
    idleWait();
    check(ssiData === 1'b1, "R2", "idle line", int'(ssiData), 1);

    // R4: posWord changes during the frame
    curReq = "R4";
    posWord = 16'h1234;
    burst(6, 6);
    posWord = 16'hFFFF;
    burst(FRAME_W - 6, 6);
    idleWait();

    // R6: pause shorter than the timeout, then resume
    curReq = "R6";
    posWord = 16'h0F0F;
    burst(5, 6);
    repeat (TM / 2) @(negedge clk);
    burst(FRAME_W - 5, 6);
    idleWait();

    // R5: underclocked burst times out
    curReq = "R5";
    burst(7, 6);
    repeat (TM + 2) @(negedge clk);
    check(ssiData === 1'b0, "R5", "low after timeout", int'(ssiData), 0);
    repeat (TM) @(negedge clk);
    check(ssiData === 1'b1, "R5", "high after second timeout", int'(ssiData), 1);
    idleWait();

    // R7: overclocked burst, falls retrigger the low phase
    curReq = "R7";
    burst(FRAME_W + 3, 6);
    check(ssiData === 1'b0, "R7", "low after extra edges", int'(ssiData), 0);
    repeat (TM - 12) @(negedge clk);
    check(ssiData === 1'b0, "R7", "still low after retrigger", int'(ssiData), 0);
    repeat (12) @(negedge clk);
    check(ssiData === 1'b1, "R7", "high after last fall + tm", int'(ssiData), 1);
    idleWait();

    // R9: error event, then one more reporting frame
    curReq = "R9";
    errEvent = 1'b1;
    repeat (5) @(negedge clk);
    burst(FRAME_W, 6);
    check(firstBit === 1'b1, "R9", "status while active", int'(firstBit), 1);
    errEvent = 1'b0;
    idleWait();
    burst(FRAME_W, 6);
    check(firstBit === 1'b1, "R9", "status one frame after clear", int'(firstBit), 1);
    idleWait();
    burst(FRAME_W, 6);
    check(firstBit === 1'b0, "R9", "status cleared", int'(firstBit), 0);
    idleWait();

    // R8: boundary spacing, then too fast
    curReq = "R8";
    burst(FRAME_W, 4);
    check(clkTooFast === 1'b0, "R8", "spacing equal to MIN_HALF", int'(clkTooFast), 0);
    idleWait();
    burst(FRAME_W, 3);
    check(clkTooFast === 1'b1, "R8", "flag after fast burst", int'(clkTooFast), 1);
    idleWait();
    check(clkTooFast === 1'b0, "R8", "flag cleared at frame end", int'(clkTooFast), 0);
    burst(FRAME_W, 6);
    check(firstBit === 1'b1, "R8", "status reports fast clock", int'(firstBit), 1);
    idleWait();
    burst(FRAME_W, 6);
    check(firstBit === 1'b0, "R8", "status clear afterwards", int'(firstBit), 0);
    idleWait();

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule